// File: doc/BRIEF.md
# Burst SRAM Address Controller

This block is the address front end of a synchronous burst cache RAM. On every rising clock edge it looks at two competing address strobes (one driven by the processor, one by the cache controller), three chip-select inputs and an advance input. When an access is accepted it registers the whole word address and seeds a two-bit wrap-around burst counter from the address's two low bits. Later edges with no strobe either step the counter or hold it, so the array sees the remaining words of a four-word line without the address bus changing.

The counter walks the line in one of two orders, chosen by an order input: interleaved (the low bits are the seed XOR the step number) or linear (the low bits count up modulo four). The outputs are the current array address, a flag that tells whether the device is selected, and a one-cycle pulse that marks the start of each accepted access. The array, the data path and the output enables sit outside this block.

Top module: `burst_addr_ctrl`

## Requirements
- R1: An edge accepts an access only when sel1_n_i is 0, sel2_i is 1, sel3_n_i is 0 and at least one strobe is honoured. After an accepting edge, selected_o is 1 and start_o is 1 for exactly that one cycle.
- R2: When both strobes are 0 at the same edge, the processor strobe is taken. The edge produces a single start, and the loaded address is addr_i.
- R3: The processor strobe has no effect while sel1_n_i is 1. At such an edge, the controller strobe alone decides whether the edge starts an access, deselects the device, or leaves the burst to the advance input.
- R4: An accepting edge registers all ADDR_W bits of addr_i. The next value of addr_o equals addr_i, and bits [1:0] become the burst seed.
- R5: With order_interleave_i at 1, step k of a burst puts (seed XOR k) on addr_o[1:0]. Seed 01 gives 01, 00, 11, 10.
- R6: With order_interleave_i at 0, addr_o[1:0] increments by one modulo four on each step. Seed 11 gives 11, 00, 01, 10.
- R7: At an edge with no honoured strobe, advance_n_i at 0 steps the counter once and advance_n_i at 1 holds addr_o unchanged. This applies whether or not the device is selected. Such an edge never changes selected_o and leaves start_o at 0.
- R8: After the fourth address the counter returns to the seed. Stepping never changes addr_o[ADDR_W-1:2].
- R9: A honoured strobe while any chip select is inactive deselects the device. This covers the controller strobe with any select off, and the processor strobe with sel1_n_i at 0 but sel2_i or sel3_n_i inactive. Such an edge sets selected_o to 0 and start_o to 0, and holds addr_o.
- R10: While rst_ni is 0 (asynchronously applied), addr_o is 0, selected_o is 0 and start_o is 0, and the burst counter restarts from seed 00 and step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_strobe_n_i | input | 1 | Processor address strobe, active low |
| ctl_strobe_n_i | input | 1 | Cache controller address strobe, active low |
| sel1_n_i | input | 1 | Chip select 1, active low; also gates the processor strobe |
| sel2_i | input | 1 | Chip select 2, active high |
| sel3_n_i | input | 1 | Chip select 3, active low |
| advance_n_i | input | 1 | Burst advance, active low |
| order_interleave_i | input | 1 | 1 selects interleaved order, 0 selects linear |
| addr_i | input | ADDR_W | Word address presented with a strobe |
| addr_o | output | ADDR_W | Current array address |
| selected_o | output | 1 | Device selected flag |
| start_o | output | 1 | One-cycle pulse after an accepted access |

## Verification
Bursts are started with each strobe alone and with both strobes together. They are run in both orders from the seeds 00, 01, 10 and 11, so that an XOR walk and an increment walk give different low bits at the second step. Advance pulses are interleaved with holds, which separates a suspended burst from a stepping one. One burst runs past its fourth word, which shows that the counter wraps to the seed and that the upper bits stay put. Strobes are applied with each chip select turned off in turn, and the processor strobe is applied with sel1_n_i high. These patterns distinguish a deselect from an ignored strobe by whether addr_o still steps on the advance input. An asynchronous reset applied in the middle of a burst, followed by an advance step, shows that the counter restarts from seed zero.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // Width of the wrap-around burst counter (four-word line).
  localparam int unsigned BURST_W = 2;

  // Action decided for one clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,  // no strobe, burst suspended
    ACT_STEP = 2'd1,  // no strobe, advance one word
    ACT_LOAD = 2'd2,  // strobe accepted, new access
    ACT_DROP = 2'd3   // strobe seen, device deselected
  } edge_act_t;
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
  import burst_addr_pkg::*;
(
  input  logic      cpu_strobe_n_i,
  input  logic      ctl_strobe_n_i,
  input  logic      sel1_n_i,
  input  logic      sel2_i,
  input  logic      sel3_n_i,
  input  logic      advance_n_i,
  output edge_act_t act_o
);
  logic proc_take;
  logic ctl_take;
  logic chips_on;

  always_comb begin
    // Processor strobe only counts when select 1 is active.
    proc_take = ~cpu_strobe_n_i & ~sel1_n_i;
    // Controller strobe only counts when the processor strobe is not taken.
    ctl_take  = ~ctl_strobe_n_i & ~proc_take;
    chips_on  = ~sel1_n_i & sel2_i & ~sel3_n_i;

    if (proc_take | ctl_take) begin
      act_o = chips_on ? ACT_LOAD : ACT_DROP;
    end else begin
      act_o = advance_n_i ? ACT_HOLD : ACT_STEP;
    end
  end
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
  import burst_addr_pkg::*;
#(
  parameter int unsigned W = BURST_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  edge_act_t    act_i,
  input  logic         interleave_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] low_o
);
  logic [W-1:0] seed_q, seed_nx;
  logic [W-1:0] step_q, step_nx;
  logic [W-1:0] low_q,  low_nx;
  logic         en;
  logic [W-1:0] step_inc;

  always_comb begin
    step_inc = step_q + 1'b1;
    seed_nx  = seed_q;
    step_nx  = step_q;
    low_nx   = low_q;
    en       = 1'b0;
    unique case (act_i)
      ACT_LOAD: begin
        en      = 1'b1;
        seed_nx = seed_i;
        step_nx = '0;
        low_nx  = seed_i;
      end
      ACT_STEP: begin
        en      = 1'b1;
        step_nx = step_inc;
        low_nx  = interleave_i ? (seed_q ^ step_inc) : (low_q + 1'b1);
      end
      default: en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '0;
      step_q <= '0;
      low_q  <= '0;
    end else if (en) begin
      seed_q <= seed_nx;
      step_q <= step_nx;
      low_q  <= low_nx;
    end
  end

  assign low_o = low_q;
endmodule

// File: rtl/addr_hold_reg.sv
module addr_hold_reg #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (load_i) begin
      q <= d_i;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_strobe_n_i,
  input  logic              ctl_strobe_n_i,
  input  logic              sel1_n_i,
  input  logic              sel2_i,
  input  logic              sel3_n_i,
  input  logic              advance_n_i,
  input  logic              order_interleave_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              selected_o,
  output logic              start_o
);
  localparam int unsigned UP_W = ADDR_W - BURST_W;

  edge_act_t          act;
  logic [BURST_W-1:0] low;
  logic [UP_W-1:0]    upper;
  logic               sel_q, sel_nx;
  logic               start_q, start_nx;

  strobe_decode u_dec (
    .cpu_strobe_n_i (cpu_strobe_n_i),
    .ctl_strobe_n_i (ctl_strobe_n_i),
    .sel1_n_i       (sel1_n_i),
    .sel2_i         (sel2_i),
    .sel3_n_i       (sel3_n_i),
    .advance_n_i    (advance_n_i),
    .act_o          (act)
  );

  burst_step_ctr #(.W(BURST_W)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_i        (act),
    .interleave_i (order_interleave_i),
    .seed_i       (addr_i[BURST_W-1:0]),
    .low_o        (low)
  );

  addr_hold_reg #(.W(UP_W)) u_upper (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (act == ACT_LOAD),
    .d_i    (addr_i[ADDR_W-1:BURST_W]),
    .q_o    (upper)
  );

  always_comb begin
    sel_nx   = sel_q;
    start_nx = 1'b0;
    if (act == ACT_LOAD) begin
      sel_nx   = 1'b1;
      start_nx = 1'b1;
    end else if (act == ACT_DROP) begin
      sel_nx   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      sel_q   <= sel_nx;
      start_q <= start_nx;
    end
  end

  assign addr_o     = {upper, low};
  assign selected_o = sel_q;
  assign start_o    = start_q;
endmodule

// File: rtl/burst_addr_ctrl_chk.sv
module burst_addr_ctrl_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_strobe_n_i,
  input logic              ctl_strobe_n_i,
  input logic              sel1_n_i,
  input logic              sel2_i,
  input logic              sel3_n_i,
  input logic              advance_n_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              selected_o,
  input logic              start_o
);
  logic honoured, all_on;
  assign honoured = (~cpu_strobe_n_i & ~sel1_n_i) | ~ctl_strobe_n_i;
  assign all_on   = ~sel1_n_i & sel2_i & ~sel3_n_i;

  // R1: an accepting edge raises start and select on the next cycle
  a_r1_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    honoured && all_on |=> start_o && selected_o);

  // R1: the start pulse only ever appears while selected
  a_r1_start_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> selected_o);

  // R4: accepted address appears in full on addr_o
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    honoured && all_on |=> addr_o == $past(addr_i));

  // R9: strobe with a select off deselects and holds the address
  a_r9_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    honoured && !all_on |=> !selected_o && !start_o && $stable(addr_o));

  // R7: no strobe and no advance holds everything
  a_r7_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !honoured && advance_n_i |=> $stable(addr_o) && $stable(selected_o) && !start_o);

  // R8: stepping never touches the upper address bits
  a_r8_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !honoured |=> $stable(addr_o[ADDR_W-1:2]) && $stable(selected_o));
endmodule

bind burst_addr_ctrl burst_addr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_strobe_n_i (cpu_strobe_n_i),
  .ctl_strobe_n_i (ctl_strobe_n_i),
  .sel1_n_i       (sel1_n_i),
  .sel2_i         (sel2_i),
  .sel3_n_i       (sel3_n_i),
  .advance_n_i    (advance_n_i),
  .addr_i         (addr_i),
  .addr_o         (addr_o),
  .selected_o     (selected_o),
  .start_o        (start_o)
);

// File: tb/burst_addr_ctrl_tb.sv
module burst_addr_ctrl_tb;
  localparam int AW = 16;

  typedef struct packed {
    logic          cpu_n;
    logic          ctl_n;
    logic          s1n;
    logic          s2;
    logic          s3n;
    logic          advn;
    logic          mode;
    logic [AW-1:0] addr;
    logic [AW-1:0] exp_addr;
    logic          exp_sel;
    logic          exp_start;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    // cpu ctl s1n s2 s3n adv mode addr     exp_addr  sel st  req
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'h1231,16'h1231,1'b1,1'b1,8'd1}, // R1 R4 processor start
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h1230,1'b1,1'b0,8'd5}, // R5 01^1
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h1233,1'b1,1'b0,8'd5}, // R5 01^2
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h1232,1'b1,1'b0,8'd5}, // R5 01^3
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h1231,1'b1,1'b0,8'd8}, // R8 wrap to seed
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,16'hABCF,16'hABCF,1'b1,1'b1,8'd4}, // R4 controller start
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'hABCC,1'b1,1'b0,8'd6}, // R6 R8 11->00 upper kept
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,16'h0000,16'hABCC,1'b1,1'b0,8'd7}, // R7 suspend
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'hABCD,1'b1,1'b0,8'd6}, // R6
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'hABCE,1'b1,1'b0,8'd6}, // R6
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'hABCF,1'b1,1'b0,8'd8}, // R8 back to 11
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,16'h5552,16'h5552,1'b1,1'b1,8'd2}, // R2 both strobes
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,16'h7777,16'h5553,1'b1,1'b0,8'd3}, // R3 ignored, steps
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,16'h7777,16'h5553,1'b0,1'b0,8'd3}, // R3 ctl decides -> off
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,16'h0F02,16'h0F02,1'b1,1'b1,8'd1}, // R1
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h1111,16'h0F02,1'b0,1'b0,8'd9}, // R9 sel2 off
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h0F03,1'b0,1'b0,8'd7}, // R7 steps while off
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,16'h2222,16'h0F03,1'b0,1'b0,8'd9}, // R9 sel3 off
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h0000,1'b1,1'b1,8'd1}, // R1
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0001,1'b1,1'b0,8'd6}, // R6
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h0002,1'b1,1'b0,8'd5}  // R5 seed 00 ^ 2
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          cpu_strobe_n_i, ctl_strobe_n_i;
  logic          sel1_n_i, sel2_i, sel3_n_i;
  logic          advance_n_i, order_interleave_i;
  logic [AW-1:0] addr_i;
  logic [AW-1:0] addr_o;
  logic          selected_o, start_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  burst_addr_ctrl #(.ADDR_W(AW)) u_dut (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .cpu_strobe_n_i     (cpu_strobe_n_i),
    .ctl_strobe_n_i     (ctl_strobe_n_i),
    .sel1_n_i           (sel1_n_i),
    .sel2_i             (sel2_i),
    .sel3_n_i           (sel3_n_i),
    .advance_n_i        (advance_n_i),
    .order_interleave_i (order_interleave_i),
    .addr_i             (addr_i),
    .addr_o             (addr_o),
    .selected_o         (selected_o),
    .start_o            (start_o)
  );

  task automatic check(input string tag, input logic [AW-1:0] ea,
                       input logic es, input logic est);
    n_chk++;
    if (addr_o !== ea || selected_o !== es || start_o !== est) begin
      n_fail++;
      $display("FAIL %s: addr=%h sel=%b start=%b expected addr=%h sel=%b start=%b",
               tag, addr_o, selected_o, start_o, ea, es, est);
    end
  endtask

  task automatic idle();
    cpu_strobe_n_i = 1'b1; ctl_strobe_n_i = 1'b1;
    sel1_n_i = 1'b1; sel2_i = 1'b0; sel3_n_i = 1'b1;
    advance_n_i = 1'b1; order_interleave_i = 1'b1; addr_i = '0;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R10 reset state", '0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      cpu_strobe_n_i     = TBL[i].cpu_n;
      ctl_strobe_n_i     = TBL[i].ctl_n;
      sel1_n_i           = TBL[i].s1n;
      sel2_i             = TBL[i].s2;
      sel3_n_i           = TBL[i].s3n;
      advance_n_i        = TBL[i].advn;
      order_interleave_i = TBL[i].mode;
      addr_i             = TBL[i].addr;
      @(posedge clk_i);
      #2;
      check($sformatf("vector %0d (R%0d)", i, TBL[i].req),
            TBL[i].exp_addr, TBL[i].exp_sel, TBL[i].exp_start);
    end

    // R10: asynchronous reset in the middle of a burst
    @(negedge clk_i);
    idle();
    sel1_n_i = 1'b0; sel2_i = 1'b1; sel3_n_i = 1'b0;
    cpu_strobe_n_i = 1'b0; addr_i = 16'hBEE6;
    @(posedge clk_i); #2;
    check("R1 start before reset", 16'hBEE6, 1'b1, 1'b1);
    @(negedge clk_i);
    cpu_strobe_n_i = 1'b1; advance_n_i = 1'b0;
    @(posedge clk_i); #2;
    check("R5 step before reset", 16'hBEE7, 1'b1, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R10 async reset mid-burst", '0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    order_interleave_i = 1'b1;
    @(posedge clk_i); #2;
    check("R10 counter restarts from seed 00", 16'h0001, 1'b0, 1'b0);

    // R9: controller strobe with sel1 off deselects
    @(negedge clk_i);
    advance_n_i = 1'b1; ctl_strobe_n_i = 1'b0; sel1_n_i = 1'b1; addr_i = 16'h3333;
    @(posedge clk_i); #2;
    check("R9 controller strobe sel1 off", 16'h0001, 1'b0, 1'b0);

    // R1: start pulse lasts one cycle only
    @(negedge clk_i);
    sel1_n_i = 1'b0; addr_i = 16'h4443;
    @(posedge clk_i); #2;
    check("R1 start", 16'h4443, 1'b1, 1'b1);
    @(negedge clk_i);
    ctl_strobe_n_i = 1'b1;
    @(posedge clk_i); #2;
    check("R1 pulse drops after one cycle", 16'h4443, 1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule